// File: doc/BRIEF.md
# ADC Sample-Stream Capture Sequencer

This block stores a stream of ADC conversions in external byte-wide SRAM without help from the processor. Software first writes a list of channel IDs into memory. Each entry takes two bytes, and the ID sits in the upper nibble of the even byte. Software then loads a 24-bit base pointer and sets the enable bit. From that point the sequencer owns the memory bus. It fetches the first ID and waits for a conversion trigger. It then starts the converter on that channel and reads the next entry's ID while the conversion runs. When the converter finishes, the sequencer writes the result back over the entry it came from.

The list ends with a repeat of the last channel, followed by an entry whose ID is all ones. When the prefetched ID is all ones, the sequencer writes the current result, raises a sticky completion flag and hands the bus back. The two bytes of the stop entry are never written. Pointer and enable writes are accepted only while the converter is powered down.

Top module: `adc_dma_seq`

## Requirements
- R1: Register offsets are 0 for control, 1 for pointer low byte, 2 for pointer middle byte and 3 for pointer page byte. Writes to offsets 1 and 2 are only staged. A write to offset 3 commits {page, middle, low} as the base pointer.
- R2: All register writes are ignored while `adc_pwrdn_i` is 0. Pointer writes are also ignored while `bus_own_o` is 1.
- R3: A control write with bit 6 set, made while idle, starts a run. The first cycle reads the byte at the base pointer and takes bits 7:4 as the current channel ID. `bus_own_o` is 1 from the cycle after the write until the run completes or is aborted.
- R4: Once the current ID is loaded, a rising edge on any `trig_i` bit (bit 0 single command, bit 1 timer, bit 2 external) gives a one-cycle `adc_start_o` with `adc_ch_o` equal to that ID. Edges that arrive while a conversion is in flight, or while idle, are ignored.
- R5: A result is written in two consecutive cycles. The first byte is {ID, result[11:8]} to the entry's even address. The second byte is result[7:0] to the next address. Both writes begin the cycle after `adc_done_i`, and the pointer then advances by 2.
- R6: The next entry's ID is read during the conversion. If it is 4'hF, the current result is still written, then `irq_o` goes to 1 and `bus_own_o` to 0 in the same cycle. The stop entry's two bytes keep their contents.
- R7: If the first entry's ID is 4'hF, the run completes with no conversion and no memory write.
- R8: `irq_o` stays 1 until the next control write. A control write with bit 6 clear aborts a run, releases the bus and does not set `irq_o`. Triggers after completion or abort start nothing.
- R9: `mem_rd_o` and `mem_wr_o` are only active while `bus_own_o` is 1, and they are never active together.
- R10: After the second result byte is written, the sequencer accepts a trigger on the following cycle. The cost is four cycles per sample outside the converter's own time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| adc_pwrdn_i | input | 1 | Converter is powered down (mode bits both 0) |
| trig_i | input | 3 | Conversion trigger sources: single, timer, external |
| adc_ch_o | output | 4 | Channel to convert |
| adc_start_o | output | 1 | Start conversion, one cycle |
| adc_done_i | input | 1 | Conversion result valid, one cycle |
| adc_result_i | input | 12 | Conversion result |
| mem_addr_o | output | 24 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid in the read cycle |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| bus_own_o | output | 1 | Sequencer owns the memory bus; processor access is blocked |
| irq_o | output | 1 | Sticky completion flag |

## Verification
The hardest situation to reach is the stop decision. It depends on an ID that was prefetched from memory while a conversion was running, so it can only be driven by memory contents laid out ahead of time. The bench therefore builds lists of every length from zero to six entries in a behavioural SRAM, at several base pointers. Each list ends with the duplicated last channel and the all-ones marker, and the stop bytes hold known values. The bench sends each trigger as early as R10 allows, and adds a spurious trigger in the middle of every conversion.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  localparam int unsigned ID_W    = 4;
  localparam int unsigned RES_W   = 12;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned EN_BIT  = 6;
  localparam logic [1:0]  REG_CTRL = 2'd0;
  localparam logic [1:0]  REG_LO   = 2'd1;
  localparam logic [1:0]  REG_MID  = 2'd2;
  localparam logic [1:0]  REG_PAGE = 2'd3;
  localparam logic [ID_W-1:0] STOP_ID = '1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ARM,
    ST_PREF,
    ST_CONV,
    ST_WRH,
    ST_WRL
  } seq_state_e;
endpackage

// File: rtl/adc_dma_regs.sv
module adc_dma_regs
  import adc_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              pwrdn_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              go_o,
  output logic              halt_o,
  output logic              clr_o
);
  localparam int unsigned PTR_W = 3 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, mid_q;
  logic [ADDR_W-1:0] base_q;
  logic              wr_ok, ptr_ok, ctrl_wr;

  assign wr_ok   = we_i & pwrdn_i;
  assign ptr_ok  = wr_ok & ~busy_i;
  assign ctrl_wr = wr_ok & (addr_i == REG_CTRL);
  assign go_o    = ctrl_wr & wdata_i[EN_BIT] & ~busy_i;
  assign halt_o  = ctrl_wr & ~wdata_i[EN_BIT];
  assign clr_o   = ctrl_wr;
  assign base_o  = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      mid_q  <= '0;
      base_q <= '0;
    end else if (ptr_ok) begin
      unique case (addr_i)
        REG_LO:   lo_q  <= wdata_i;
        REG_MID:  mid_q <= wdata_i;
        REG_PAGE: base_q <= ADDR_W'(PTR_W'({wdata_i, mid_q, lo_q}));
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/adc_dma_trig.sv
module adc_dma_trig #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  output logic             fire_o
);
  logic [N_SRC-1:0] edge_w;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= src_i[g];
    end
    assign edge_w[g] = src_i[g] & ~prev_q;
  end

  assign fire_o = |edge_w;
endmodule

// File: rtl/adc_dma_ctl.sv
module adc_dma_ctl
  import adc_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              go_i,
  input  logic              halt_i,
  input  logic              clr_i,
  input  logic              fire_i,
  output logic [ID_W-1:0]   adc_ch_o,
  output logic              adc_start_o,
  input  logic              adc_done_i,
  input  logic [RES_W-1:0]  adc_result_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              busy_o,
  output logic              irq_o
);
  localparam int unsigned HI_W = BYTE_W - ID_W;

  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] ptr_q;
  logic [ID_W-1:0]   cur_q, nxt_q;
  logic [RES_W-1:0]  res_q;
  logic              irq_q;
  logic [ID_W-1:0]   rd_id;
  logic              last_w;

  assign rd_id  = mem_rdata_i[BYTE_W-1 -: ID_W];
  assign last_w = (nxt_q == STOP_ID);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (go_i) st_d = ST_FETCH;
      ST_FETCH: st_d = (rd_id == STOP_ID) ? ST_IDLE : ST_ARM;
      ST_ARM:   if (fire_i) st_d = ST_PREF;
      ST_PREF:  st_d = adc_done_i ? ST_WRH : ST_CONV;
      ST_CONV:  if (adc_done_i) st_d = ST_WRH;
      ST_WRH:   st_d = ST_WRL;
      ST_WRL:   st_d = last_w ? ST_IDLE : ST_ARM;
      default:  st_d = ST_IDLE;
    endcase
    if (halt_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      cur_q <= '0;
      nxt_q <= '0;
      res_q <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (clr_i) irq_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (go_i) ptr_q <= base_i;
        ST_FETCH: begin
          cur_q <= rd_id;
          if (rd_id == STOP_ID && !halt_i) irq_q <= 1'b1;
        end
        ST_PREF: begin
          nxt_q <= rd_id;
          if (adc_done_i) res_q <= adc_result_i;
        end
        ST_CONV: if (adc_done_i) res_q <= adc_result_i;
        ST_WRL: begin
          ptr_q <= ptr_q + ADDR_W'(2);
          cur_q <= nxt_q;
          if (last_w && !halt_i) irq_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    mem_addr_o  = ptr_q;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_PREF: mem_addr_o = ptr_q + ADDR_W'(2);
      ST_WRH:  mem_wdata_o = {cur_q, res_q[RES_W-1 -: HI_W]};
      ST_WRL: begin
        mem_addr_o  = ptr_q + ADDR_W'(1);
        mem_wdata_o = res_q[BYTE_W-1:0];
      end
      default: ;
    endcase
  end

  assign mem_rd_o    = (st_q == ST_FETCH) | (st_q == ST_PREF);
  assign mem_wr_o    = (st_q == ST_WRH) | (st_q == ST_WRL);
  assign adc_start_o = (st_q == ST_PREF);
  assign adc_ch_o    = cur_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign irq_o       = irq_q;
endmodule

// File: rtl/adc_dma_seq.sv
module adc_dma_seq
  import adc_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned N_TRIG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              adc_pwrdn_i,
  input  logic [N_TRIG-1:0] trig_i,
  output logic [3:0]        adc_ch_o,
  output logic              adc_start_o,
  input  logic              adc_done_i,
  input  logic [11:0]       adc_result_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              bus_own_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] base_w;
  logic go_w, halt_w, clr_w, fire_w, busy_w;

  adc_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .pwrdn_i (adc_pwrdn_i),
    .busy_i  (busy_w),
    .base_o  (base_w),
    .go_o    (go_w),
    .halt_o  (halt_w),
    .clr_o   (clr_w)
  );

  adc_dma_trig #(.N_SRC(N_TRIG)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (trig_i),
    .fire_o (fire_w)
  );

  adc_dma_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_i       (base_w),
    .go_i         (go_w),
    .halt_i       (halt_w),
    .clr_i        (clr_w),
    .fire_i       (fire_w),
    .adc_ch_o     (adc_ch_o),
    .adc_start_o  (adc_start_o),
    .adc_done_i   (adc_done_i),
    .adc_result_i (adc_result_i),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .busy_o       (busy_w),
    .irq_o        (irq_o)
  );

  assign bus_own_o = busy_w;
endmodule

// File: rtl/adc_dma_chk.sv
module adc_dma_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        adc_ch_o,
  input logic              adc_start_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              bus_own_o,
  input logic              irq_o
);
  AST_MEM_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> bus_own_o);                                     // R9
  AST_NO_RD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));                                                  // R9
  AST_BYTE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !mem_addr_o[0]) |=> (mem_wr_o && mem_addr_o == ADDR_W'($past(mem_addr_o) + 1))); // R5
  AST_PAIR_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && mem_addr_o[0]) |=> !mem_wr_o);                                // R10
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);                                             // R4
  AST_CH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> $stable(adc_ch_o));                                        // R4
  AST_IRQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !bus_own_o);                                              // R6
endmodule

bind adc_dma_seq adc_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .adc_ch_o    (adc_ch_o),
  .adc_start_o (adc_start_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .bus_own_o   (bus_own_o),
  .irq_o       (irq_o)
);

// File: tb/sim_adc_dma_seq.sv
`timescale 1ns/1ps
module sim_adc_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        pwrdn = 1'b1;
  logic [2:0]  trig = '0;
  logic [3:0]  adc_ch;
  logic        adc_start;
  logic        adc_done = 1'b0;
  logic [11:0] adc_res = '0;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, bus_own, irq;

  int checks = 0, fails = 0, cyc = 0;
  int nstart = 0, nwr = 0, bad_addr = 0, adc_cnt = 0;
  logic adc_busy = 1'b0;
  logic [3:0] adc_chl = '0;
  logic [15:0] exp_page = '0;
  logic [7:0] mem [256];
  logic [3:0] chlog [64];

  always #4 clk = ~clk;

  adc_dma_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .adc_pwrdn_i(pwrdn), .trig_i(trig),
    .adc_ch_o(adc_ch), .adc_start_o(adc_start), .adc_done_i(adc_done),
    .adc_result_i(adc_res), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .bus_own_o(bus_own), .irq_o(irq)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  function automatic logic [11:0] res_of(int ch, int k);
    return 12'((ch * 293 + k * 71 + 5) & 12'hFFF);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      nwr <= nwr + 1;
      if (mem_addr[23:8] != exp_page) bad_addr <= bad_addr + 1;
    end
    if (mem_rd && mem_addr[23:8] != exp_page) bad_addr <= bad_addr + 1;
    adc_done <= 1'b0;
    if (adc_start) begin
      chlog[nstart[5:0]] <= adc_ch;
      nstart   <= nstart + 1;
      adc_chl  <= adc_ch;
      adc_cnt  <= 3;
      adc_busy <= 1'b1;
    end else if (adc_busy) begin
      if (adc_cnt == 0) begin
        adc_done <= 1'b1;
        adc_res  <= res_of(int'(adc_chl), nstart);
        adc_busy <= 1'b0;
      end else adc_cnt <= adc_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic program_ptr(input logic [23:0] b);
    wr_reg(2'd1, b[7:0]);
    wr_reg(2'd2, b[15:8]);
    wr_reg(2'd3, b[23:16]);
  endtask

  task automatic pulse(input int src);
    trig[src] = 1'b1;
    @(negedge clk);
    trig[src] = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!adc_done && t < 100) begin @(negedge clk); t++; end
  endtask

  task automatic preload(input logic [7:0] lo, input int n, input int seed, output logic [3:0] ids [8]);
    for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
    for (int i = 0; i < n; i++) ids[i] = 4'((seed * 3 + i * 5) % 15);
    if (n >= 2) ids[n-1] = ids[n-2];
    for (int i = 0; i < n; i++) begin
      mem[8'(lo + 8'(2*i))]     = {ids[i], 4'h3};
      mem[8'(lo + 8'(2*i + 1))] = 8'hC3;
    end
    mem[8'(lo + 8'(2*n))]     = 8'hF7;
    mem[8'(lo + 8'(2*n + 1))] = 8'h5A;
  endtask

  task automatic run_list(input logic [23:0] b, input int n, input int seed, input bit prog);
    logic [3:0] ids [8];
    int s0, w0;
    preload(b[7:0], n, seed, ids);
    exp_page = b[23:8];
    if (prog) program_ptr(b);
    s0 = nstart; w0 = nwr;
    wr_reg(2'd0, 8'h40);
    chk(irq == 1'b0, "R8 irq clear on ctrl write", irq, 0);
    @(negedge clk);
    if (n == 0) begin
      @(negedge clk);
      chk(irq == 1'b1, "R7 empty list irq", irq, 1);
      chk(bus_own == 1'b0, "R7 empty list bus", bus_own, 0);
    end else begin
      chk(bus_own == 1'b1, "R3 bus owned", bus_own, 1);
      for (int i = 0; i < n; i++) begin
        pulse((seed + i) % 3);
        @(negedge clk);
        pulse((seed + i + 1) % 3);
        wait_done();
        repeat (3) @(negedge clk);
        if (i < n - 1) chk(bus_own == 1'b1 && irq == 1'b0, "R6 still running", {bus_own, irq}, 2);
      end
      chk(irq == 1'b1, "R6 irq at stop", irq, 1);
      chk(bus_own == 1'b0, "R6 bus released", bus_own, 0);
    end
    chk(nstart - s0 == n, "R4 conversion count", nstart - s0, n);
    chk(nwr - w0 == 2 * n, "R5 write count", nwr - w0, 2 * n);
    for (int i = 0; i < n; i++) begin
      logic [11:0] r;
      r = res_of(int'(ids[i]), s0 + i + 1);
      chk(chlog[6'(s0 + i)] == ids[i], "R4 channel order", chlog[6'(s0 + i)], ids[i]);
      chk(mem[8'(b[7:0] + 8'(2*i))] == {ids[i], r[11:8]}, "R5 high byte",
          mem[8'(b[7:0] + 8'(2*i))], {ids[i], r[11:8]});
      chk(mem[8'(b[7:0] + 8'(2*i + 1))] == r[7:0], "R5 low byte",
          mem[8'(b[7:0] + 8'(2*i + 1))], r[7:0]);
    end
    chk(mem[8'(b[7:0] + 8'(2*n))] == 8'hF7 && mem[8'(b[7:0] + 8'(2*n + 1))] == 8'h5A,
        "R6 stop entry untouched", mem[8'(b[7:0] + 8'(2*n))], 8'hF7);
    chk(bad_addr == 0, "R1 address page", bad_addr, 0);
    s0 = nstart;
    pulse(0); pulse(2);
    repeat (3) @(negedge clk);
    chk(nstart == s0, "R8 trigger after stop ignored", nstart - s0, 0);
    chk(irq == 1'b1, "R8 irq sticky", irq, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
    repeat (3) @(negedge clk);
    chk(bus_own == 0 && irq == 0 && adc_start == 0 && mem_rd == 0 && mem_wr == 0,
        "R3 reset state", {bus_own, irq, adc_start, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 1; n <= 6; n++) begin
      run_list({8'h12 + 8'(n), 8'h34, 8'h20 + 8'(2*n)}, n, n, 1'b1);
      run_list({8'hC0 - 8'(n), 8'h0F * 8'(n), 8'h80 + 8'(4*n)}, n, n + 7, 1'b1);
    end
    run_list(24'h5A_A5_40, 0, 2, 1'b1);

    // R2: gated writes while converter powered up, R1: staged bytes without page commit
    run_list(24'h33_44_10, 2, 4, 1'b1);
    pwrdn = 1'b0;
    program_ptr(24'h77_88_60);
    pwrdn = 1'b1;
    run_list(24'h33_44_10, 3, 5, 1'b0);
    wr_reg(2'd1, 8'h60);
    wr_reg(2'd2, 8'h88);
    run_list(24'h33_44_10, 2, 6, 1'b0);
    pwrdn = 1'b0;
    wr_reg(2'd0, 8'h40);
    @(negedge clk);
    chk(bus_own == 1'b0, "R2 enable ignored powered up", bus_own, 0);
    pwrdn = 1'b1;

    // R8: abort mid-run
    begin
      logic [3:0] ids [8];
      int s0;
      preload(8'h10, 4, 3, ids);
      exp_page = 16'h3344;
      wr_reg(2'd0, 8'h40);
      pulse(1);
      wait_done();
      repeat (3) @(negedge clk);
      wr_reg(2'd0, 8'h00);
      chk(bus_own == 1'b0, "R8 abort releases bus", bus_own, 0);
      chk(irq == 1'b0, "R8 abort no irq", irq, 0);
      s0 = nstart;
      pulse(2);
      repeat (3) @(negedge clk);
      chk(nstart == s0, "R8 trigger after abort ignored", nstart - s0, 0);
      chk(mem[8'h12] == {ids[1], 4'h3}, "R8 abort leaves entry", mem[8'h12], {ids[1], 4'h3});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    fails++;
    checks++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule